// File: doc/BRIEF.md
# Slave Address Window Decoder

This block decides whether an incoming bus slave cycle belongs to the local board. It has two independent windows. The short window matches the upper byte of a 16-bit I/O address. The memory window matches the upper sixteen bits of a 32-bit address, or the upper eight bits of a 24-bit address. Each window is defined by a compare value and a mask. A set mask bit makes the matching address bit a don't-care. Clearing the mask leaves a 64-Kbyte memory window, and setting the mask from bit 0 upward doubles the window once for each bit.

A shared control word qualifies both windows. It can restrict selection to supervisory address-modifier codes and it can refuse 32-bit data cycles. For the memory window it also chooses the address space. Software programs the block through a small indexed write port. A window stays disarmed until its compare register has been written and then its mask register has been written.

The per-window hit flags are combinational from the address, the modifier and the width flag. The select outputs capture those flags on the clock edge where the address strobe is high, and keep them until the next strobe.

Top module: `slvdec_top`

## Requirements
- R1: After reset, both select outputs are 0, all registers are 0 and both windows are disarmed, so neither match output is 1 for any address.
- R2: The short window matches only for modifier codes 0x29 or 0x2D, when bus_addr[15:8] equals compare bits [15:8] on every position where mask bits [15:8] are 0. Compare and mask bits [7:0] and bus_addr[7:0] have no effect.
- R3: With space field 00, the memory window matches only modifier codes with am[5:3]=001 and am[1:0]≠00, when bus_addr[31:16] equals the compare register on every unmasked bit.
- R4: With space field 01, the memory window matches only modifier codes with am[5:3]=111 and am[1:0]≠00, comparing bus_addr[23:16] against compare/mask bits [7:0]. bus_addr[31:24] and compare/mask bits [15:8] have no effect. With space field 10 or 11 the memory window never matches.
- R5: With mask bits [k-1:0] set and all other mask bits clear, an aligned memory window spans 64 Kbytes times 2^k. The last byte inside the window matches, and the bytes just below and just above it do not.
- R6: A compare write disarms its window. A later mask write arms it. A mask write with no compare write since reset leaves the window disarmed. A disarmed window never matches.
- R7: When control bit 5 is set, only modifier codes with am[2]=1 (supervisory) can match either window.
- R8: When control bit 4 is clear, a cycle with xfer_d32 high matches neither window. When control bit 4 is set, xfer_d32 has no effect.
- R9: On a clock edge where addr_strobe is high, sel_short and sel_mem take the current match values. On a clock edge where addr_strobe is low, they hold.
- R10: Write index 0 loads the short compare register, 1 the short mask, 2 the memory compare, 3 the memory mask, and 4 the control word (bit 5 supervisory-only, bit 4 32-bit enable, bits 3:2 space).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 16 | Register write data |
| bus_addr | input | 32 | Slave cycle address |
| bus_am | input | 6 | Slave cycle address modifier |
| xfer_d32 | input | 1 | Cycle is a 32-bit data transfer |
| addr_strobe | input | 1 | Address valid; captures select outputs |
| match_short | output | 1 | Combinational short-window hit |
| match_mem | output | 1 | Combinational memory-window hit |
| sel_short | output | 1 | Short-window select captured on strobe |
| sel_mem | output | 1 | Memory-window select captured on strobe |

## Verification
A corrupted arming flag shows up on the match outputs in the same cycle as the next probe. The window either answers before its mask write or stays silent after it. A bad compare or mask bit shows only at the addresses that differ in that bit. For this reason the bench sweeps every value of the decoded address byte, and it probes both edges of each enlarged memory window. A wrong select register appears one clock after a strobe, or as a change on a clock edge where the strobe was low.

// File: rtl/slvdec_pkg.sv
package slvdec_pkg;

    localparam int AM_W  = 6;
    localparam int REG_W = 16;
    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_SHORT_CMP = 3'd0,
        IDX_SHORT_MSK = 3'd1,
        IDX_MEM_CMP   = 3'd2,
        IDX_MEM_MSK   = 3'd3,
        IDX_CTRL      = 3'd4
    } reg_idx_e;

    typedef enum logic [1:0] {
        SPACE_WIDE = 2'b00,
        SPACE_STD  = 2'b01,
        SPACE_OFF2 = 2'b10,
        SPACE_OFF3 = 2'b11
    } space_e;

    typedef struct packed {
        logic   sup_only;
        logic   wide_ok;
        space_e space;
    } ctrl_t;

    typedef struct packed {
        logic short_cls;
        logic std_cls;
        logic wide_cls;
        logic sup;
    } am_class_t;

    function automatic am_class_t classify_am(logic [AM_W-1:0] am);
        am_class_t c;
        c.short_cls = (am[5:3] == 3'b101) && (am[1:0] == 2'b01);
        c.std_cls   = (am[5:3] == 3'b111) && (am[1:0] != 2'b00);
        c.wide_cls  = (am[5:3] == 3'b001) && (am[1:0] != 2'b00);
        c.sup       = am[2];
        return c;
    endfunction

endpackage

// File: rtl/slvdec_regs.sv
module slvdec_regs
    import slvdec_pkg::*;
#(
    parameter int SHORT_BITS = 8,
    parameter int MEM_BITS   = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [REG_W-1:0]      wr_data,
    output logic [SHORT_BITS-1:0] short_cmp,
    output logic [SHORT_BITS-1:0] short_msk,
    output logic [MEM_BITS-1:0]   mem_cmp,
    output logic [MEM_BITS-1:0]   mem_msk,
    output ctrl_t                 ctrl,
    output logic [1:0]            armed
);

    localparam int SHORT_TOP = REG_W - 1;

    logic [1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            short_cmp <= '0;
            short_msk <= '0;
            mem_cmp   <= '0;
            mem_msk   <= '0;
            ctrl      <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_SHORT_CMP: short_cmp <= wr_data[SHORT_TOP -: SHORT_BITS];
                IDX_SHORT_MSK: short_msk <= wr_data[SHORT_TOP -: SHORT_BITS];
                IDX_MEM_CMP:   mem_cmp   <= wr_data[MEM_BITS-1:0];
                IDX_MEM_MSK:   mem_msk   <= wr_data[MEM_BITS-1:0];
                IDX_CTRL:      ctrl      <= ctrl_t'(wr_data[5:2]);
                default: ;
            endcase
        end
    end

    // Arming sequence, one copy per window: compare then mask.
    for (genvar w = 0; w < 2; w++) begin : g_arm
        localparam logic [IDX_W-1:0] CMP_I = (w == 0) ? IDX_SHORT_CMP : IDX_MEM_CMP;
        localparam logic [IDX_W-1:0] MSK_I = (w == 0) ? IDX_SHORT_MSK : IDX_MEM_MSK;
        logic cmp_wr, msk_wr;
        assign cmp_wr = wr_en && (wr_idx == CMP_I);
        assign msk_wr = wr_en && (wr_idx == MSK_I);

        always_ff @(posedge clk) begin
            if (rst) begin
                armed[w] <= 1'b0;
                pend[w]  <= 1'b0;
            end else if (cmp_wr) begin
                armed[w] <= 1'b0;
                pend[w]  <= 1'b1;
            end else if (msk_wr) begin
                armed[w] <= armed[w] | pend[w];
                pend[w]  <= 1'b0;
            end
        end

        p_cmp_disarms_r6: assert property (@(posedge clk) disable iff (rst)
            cmp_wr |=> !armed[w])
            else $error("compare write left window armed");

        p_orphan_mask_r6: assert property (@(posedge clk) disable iff (rst)
            (msk_wr && !armed[w] && !pend[w]) |=> !armed[w])
            else $error("mask write without compare armed window");
    end

endmodule

// File: rtl/slvdec_window.sv
module slvdec_window #(
    parameter int W = 8
) (
    input  logic [W-1:0] addr_bits,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] msk,
    input  logic         armed,
    input  logic         qualify,
    output logic         hit
);

    logic [W-1:0] diff;

    always_comb begin
        diff = (addr_bits ^ cmp) & ~msk;
        hit  = armed && qualify && (diff == '0);
    end

endmodule

// File: rtl/slvdec_top.sv
module slvdec_top
    import slvdec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SHORT_BITS = 8,
    parameter int MEM_BITS   = 16,
    parameter int STD_BITS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [AM_W-1:0]   bus_am,
    input  logic              xfer_d32,
    input  logic              addr_strobe,
    output logic              match_short,
    output logic              match_mem,
    output logic              sel_short,
    output logic              sel_mem
);

    localparam int SHORT_LSB = REG_W - SHORT_BITS;
    localparam int MEM_LSB   = ADDR_W - MEM_BITS;

    logic [SHORT_BITS-1:0] short_cmp, short_msk;
    logic [MEM_BITS-1:0]   mem_cmp, mem_msk;
    ctrl_t                 ctrl;
    logic [1:0]            armed;
    am_class_t             cls;
    logic                  base_ok, hit_wide, hit_std;
    logic                  unused_low;

    assign unused_low = ^bus_addr[SHORT_LSB-1:0];

    slvdec_regs #(.SHORT_BITS(SHORT_BITS), .MEM_BITS(MEM_BITS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .short_cmp(short_cmp), .short_msk(short_msk),
        .mem_cmp(mem_cmp), .mem_msk(mem_msk), .ctrl(ctrl), .armed(armed)
    );

    always_comb begin
        cls     = classify_am(bus_am);
        base_ok = (!ctrl.sup_only || cls.sup) && (ctrl.wide_ok || !xfer_d32);
    end

    slvdec_window #(.W(SHORT_BITS)) u_short (
        .addr_bits(bus_addr[REG_W-1:SHORT_LSB]), .cmp(short_cmp), .msk(short_msk),
        .armed(armed[0]), .qualify(base_ok && cls.short_cls), .hit(match_short)
    );

    slvdec_window #(.W(MEM_BITS)) u_wide (
        .addr_bits(bus_addr[ADDR_W-1:MEM_LSB]), .cmp(mem_cmp), .msk(mem_msk),
        .armed(armed[1]), .qualify(base_ok && cls.wide_cls && ctrl.space == SPACE_WIDE),
        .hit(hit_wide)
    );

    slvdec_window #(.W(STD_BITS)) u_std (
        .addr_bits(bus_addr[MEM_LSB+STD_BITS-1:MEM_LSB]),
        .cmp(mem_cmp[STD_BITS-1:0]), .msk(mem_msk[STD_BITS-1:0]),
        .armed(armed[1]), .qualify(base_ok && cls.std_cls && ctrl.space == SPACE_STD),
        .hit(hit_std)
    );

    assign match_mem = hit_wide | hit_std;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_short <= 1'b0;
            sel_mem   <= 1'b0;
        end else if (addr_strobe) begin
            sel_short <= match_short;
            sel_mem   <= match_mem;
        end
    end

    p_unarmed_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!armed[1] |-> !match_mem) and (!armed[0] |-> !match_short))
        else $error("disarmed window matched");

    p_sup_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sup_only && (match_mem || match_short)) |-> bus_am[2])
        else $error("non-supervisory code selected");

    p_d32_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.wide_ok && xfer_d32) |-> !(match_mem || match_short))
        else $error("refused 32-bit cycle matched");

    p_space_off_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl.space[1] |-> !match_mem)
        else $error("memory window matched in unused space");

    p_capture_r9: assert property (@(posedge clk) disable iff (rst)
        addr_strobe |=> (sel_mem == $past(match_mem)) && (sel_short == $past(match_short)))
        else $error("select not captured on strobe");

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !addr_strobe |=> $stable(sel_mem) && $stable(sel_short))
        else $error("select changed without strobe");

endmodule

// File: tb/slvdec_top_test.sv
module slvdec_top_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [31:0] bus_addr = '0;
    logic [5:0]  bus_am = '0;
    logic        xfer_d32 = 1'b0;
    logic        addr_strobe = 1'b0;
    logic        match_short, match_mem, sel_short, sel_mem;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state, written only through wr()
    logic [15:0] s_cmp = 0, s_msk = 0, m_cmp = 0, m_msk = 0, ctl = 0;
    bit s_arm = 0, s_pend = 0, m_arm = 0, m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slvdec_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .bus_addr(bus_addr), .bus_am(bus_am), .xfer_d32(xfer_d32),
        .addr_strobe(addr_strobe), .match_short(match_short), .match_mem(match_mem),
        .sel_short(sel_short), .sel_mem(sel_mem)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h am=%h act=%0b exp=%0b", tag, bus_addr, bus_am, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx[2:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (idx)
            0: begin s_cmp = d; s_arm = 0; s_pend = 1; end
            1: begin s_msk = d; s_arm = s_arm | s_pend; s_pend = 0; end
            2: begin m_cmp = d; m_arm = 0; m_pend = 1; end
            3: begin m_msk = d; m_arm = m_arm | m_pend; m_pend = 0; end
            4: ctl = d;
            default: ;
        endcase
    endtask

    function automatic bit exp_short(logic [31:0] a, logic [5:0] am, bit d32);
        if (!s_arm) return 0;
        if (am != 6'h29 && am != 6'h2D) return 0;
        if (ctl[5] && am != 6'h2D) return 0;
        if (!ctl[4] && d32) return 0;
        return ((a[15:8] ^ s_cmp[15:8]) & ~s_msk[15:8]) == 8'h00;
    endfunction

    function automatic bit exp_mem(logic [31:0] a, logic [5:0] am, bit d32);
        int hi;
        if (!m_arm) return 0;
        if (ctl[5] && !am[2]) return 0;
        if (!ctl[4] && d32) return 0;
        hi = int'(a >> 16);
        if (ctl[3:2] == 2'b00) begin
            if ((am >> 3) != 1 || (am % 4) == 0) return 0;
            return ((hi ^ int'(m_cmp)) & ~int'(m_msk) & 'hFFFF) == 0;
        end else if (ctl[3:2] == 2'b01) begin
            if ((am >> 3) != 7 || (am % 4) == 0) return 0;
            return ((hi ^ int'(m_cmp)) & ~int'(m_msk) & 'hFF) == 0;
        end
        return 0;
    endfunction

    task automatic probe(string tag, logic [31:0] a, logic [5:0] am, bit d32);
        @(negedge clk);
        bus_addr = a; bus_am = am; xfer_d32 = d32;
        #1;
        chk({tag, " short"}, match_short, exp_short(a, am, d32));
        chk({tag, " mem"},   match_mem,   exp_mem(a, am, d32));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 sel_short", sel_short, 1'b0);
        chk("R1 sel_mem", sel_mem, 1'b0);
        probe("R1", 32'h0000_0000, 6'h09, 0);
        probe("R1", 32'h0000_0000, 6'h2D, 0);
        probe("R1", 32'h0000_0000, 6'h39, 0);

        // R6: mask write without compare stays disarmed
        wr(1, 16'h0000);
        wr(3, 16'h0000);
        wr(4, 16'h0010);
        probe("R6 orphan", 32'h0000_0000, 6'h2D, 0);
        probe("R6 orphan", 32'h0000_0000, 6'h09, 0);

        // R2, R10: short window sweep, low bytes of registers set to junk
        wr(0, 16'hA55A);
        probe("R6 cmp only", 32'h0000_A500, 6'h2D, 0);
        wr(1, 16'h0FC3);
        for (int i = 0; i < 256; i++) begin
            probe("R2 sweep", {16'h0000, i[7:0], 8'(i * 7)}, 6'h2D, 0);
            probe("R2 user", {16'h0000, i[7:0], 8'h00}, 6'h29, 0);
        end
        probe("R2 wrong am", 32'h0000_A500, 6'h39, 0);
        probe("R2 wrong am", 32'h0000_A500, 6'h2C, 0);

        // R3: 32-bit space sweep
        wr(2, 16'h1234);
        wr(3, 16'h0000);
        for (int i = 0; i < 256; i++)
            probe("R3 sweep", {8'h12, i[7:0], 16'hBEEF}, 6'h0D, 0);
        probe("R3 am", 32'h1234_0000, 6'h09, 1);
        probe("R3 am", 32'h1234_0000, 6'h08, 0);
        probe("R3 am", 32'h1234_0000, 6'h3D, 0);

        // R5: window size doubling
        wr(2, 16'h1200);
        for (int k = 0; k <= 8; k++) begin
            logic [31:0] sz;
            sz = 32'h0001_0000 << k;
            wr(3, 16'((1 << k) - 1));
            probe("R5 last", 32'h1200_0000 + sz - 1, 6'h09, 0);
            probe("R5 above", 32'h1200_0000 + sz, 6'h09, 0);
            probe("R5 below", 32'h11FF_FFFF, 6'h09, 0);
            probe("R5 first", 32'h1200_0000, 6'h09, 0);
        end

        // R4: 24-bit space; upper compare byte and upper address byte ignored
        wr(4, 16'h0014);
        wr(2, 16'hFF3C);
        wr(3, 16'h0300);
        for (int i = 0; i < 256; i++)
            probe("R4 sweep", {8'(i * 13), i[7:0], 16'h0042}, 6'h3D, 0);
        probe("R4 am", 32'h003C_0000, 6'h0D, 0);
        probe("R4 am", 32'h003C_0000, 6'h3C, 0);
        wr(4, 16'h0018);
        probe("R4 off", 32'h003C_0000, 6'h3D, 0);
        probe("R4 off", 32'hFF3C_0000, 6'h0D, 0);
        wr(4, 16'h001C);
        probe("R4 off", 32'h003C_0000, 6'h3D, 0);

        // R7: supervisory only
        wr(4, 16'h0030);
        wr(2, 16'h4000);
        wr(3, 16'h0000);
        probe("R7 user", 32'h4000_0000, 6'h09, 0);
        probe("R7 sup", 32'h4000_0000, 6'h0D, 0);
        probe("R7 short user", 32'h0000_A500, 6'h29, 0);
        probe("R7 short sup", 32'h0000_A500, 6'h2D, 0);

        // R8: 32-bit data gating
        wr(4, 16'h0000);
        probe("R8 d32 off", 32'h4000_0000, 6'h09, 1);
        probe("R8 d16", 32'h4000_0000, 6'h09, 0);
        probe("R8 short d32 off", 32'h0000_A500, 6'h2D, 1);
        wr(4, 16'h0010);
        probe("R8 d32 on", 32'h4000_0000, 6'h09, 1);

        // R6: compare rewrite disarms until mask written
        wr(2, 16'h4000);
        probe("R6 rewrite", 32'h4000_0000, 6'h09, 0);
        wr(3, 16'h0000);
        probe("R6 rearmed", 32'h4000_0000, 6'h09, 0);

        // R9: select capture and hold
        @(negedge clk);
        bus_addr = 32'h4000_0000; bus_am = 6'h09; xfer_d32 = 0; addr_strobe = 1;
        @(negedge clk);
        addr_strobe = 0;
        chk("R9 capture mem", sel_mem, 1'b1);
        chk("R9 capture short", sel_short, 1'b0);
        bus_addr = 32'h0000_A500; bus_am = 6'h2D;
        @(negedge clk);
        chk("R9 hold mem", sel_mem, 1'b1);
        chk("R9 hold short", sel_short, 1'b0);
        addr_strobe = 1;
        @(negedge clk);
        addr_strobe = 0;
        chk("R9 recapture mem", sel_mem, 1'b0);
        chk("R9 recapture short", sel_short, 1'b1);

        // R1: reset again clears selects and disarms
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        s_cmp = 0; s_msk = 0; m_cmp = 0; m_msk = 0; ctl = 0;
        s_arm = 0; s_pend = 0; m_arm = 0; m_pend = 0;
        chk("R1 reset sel_short", sel_short, 1'b0);
        probe("R1 after", 32'h0000_0000, 6'h2D, 0);
        probe("R1 after", 32'h0000_0000, 6'h09, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule